// File: doc/BRIEF.md
# Converter Enable and Fault Sequencer

This block decides, clock by clock, whether a step-down converter switches, sits in pass-through with its high-side switch held closed, or stays off with its output discharge path engaged. It watches the enable pin, the supply-good flag and the overcurrent and over-temperature comparators. It also takes the configuration fields that a register bank supplies: a run gate, an enable override, a discharge enable, a forced mode and an overcurrent policy. A free-running millisecond tick times the slow windows.

When power is present, a start-up pass first waits a fixed number of clock cycles while the trim store is read. The sequencer then either starts regulation, which raises a one-cycle soft-start request, or enters pass-through. Overcurrent is handled by one of three policies: a timed hiccup that restarts on its own, a latched shutdown, or no action because the pulse logic limits current by itself. Over-temperature stops switching until the flag clears, and the converter then restarts through soft-start. Changes into and out of pass-through are kept a minimum number of millisecond ticks apart.

Top module: `conv_seq`

## Requirements
- R1: After reset, and while no enable source is present, the switching and pass-through outputs are low, the discharge output is high and no pulse output is asserted.
- R2: With supply good, run gate high and the pin (or override) high, switching starts after the trim-read wait of OTP_CYCLES clock cycles plus at most four cycles. The soft-start request is high for exactly the first cycle of switching.
- R3: Switching requires the run gate AND (pin OR override). With the override at 1 the pin is ignored, so the converter keeps running after the pin returns low.
- R4: With the pin low and the override at 0, the converter is off and discharge is on. With the run gate cleared while enabled, discharge equals the discharge-enable field.
- R5: Overcurrent policy 0 (hiccup) stops switching on the next cycle and gives exactly one hiccup pulse. Switching resumes with a soft-start request after HICCUP_MS millisecond ticks.
- R6: Overcurrent policy 1 (latch) stops switching and gives one latch pulse. Switching stays off until a rising edge of the run gate or of the pin.
- R7: Overcurrent policies 2 and 3 leave switching running and produce no fault pulse.
- R8: Over-temperature stops switching and gives one thermal pulse per event. When the flag clears, switching resumes with a soft-start request.
- R9: Forced-mode value 3 holds the pass-through output high with switching off, even with the run gate at 0, and overcurrent has no effect there. Values 0, 1 and 2 allow normal regulation.
- R10: Pass-through entry and exit chosen by the sequencer are at least BYP_GAP_MS millisecond ticks apart.
- R11: Loss of supply-good, or the loss of the enable source, forces the idle state from any state and cancels a pending hiccup wait. Return of power goes through the trim-read wait again.
- R12: At most one of switching, pass-through and discharge is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | External enable pin level |
| uvlo_ok | input | 1 | Supply above the lockout threshold |
| oc_flag | input | 1 | Inductor peak-current limit reached |
| ot_flag | input | 1 | Die temperature above the shutdown threshold |
| run_bit | input | 1 | Register run gate, ANDed with the enable source |
| en_ovr | input | 1 | Register override standing in for the pin |
| dis_en | input | 1 | Discharge while stopped by the run gate |
| fmode | input | 2 | 0 auto, 1 ultrasonic, 2 forced PWM, 3 forced pass-through |
| oc_mode | input | 2 | 0 hiccup, 1 latch, 2 or 3 limit only |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sw_en | output | 1 | Switching allowed |
| byp_on | output | 1 | High-side switch held closed |
| dis_on | output | 1 | Output discharge resistor engaged |
| ss_req | output | 1 | One-cycle soft-start request |
| hiccup_evt | output | 1 | One-cycle pulse on hiccup shutdown |
| latch_evt | output | 1 | One-cycle pulse on latched shutdown |
| therm_evt | output | 1 | One-cycle pulse on thermal shutdown |

## Verification
The bench holds pass-through requests from the moment one change has happened. A sequencer without spacing would flip pass-through within two cycles, and the bench catches that. A hiccup is interrupted by supply loss to show that recovery goes through the short trim-read wait. A design that kept the hiccup timer would return only after the millisecond window. The latched policy is held for many cycles and then cleared once by the run gate and once by the pin, which catches a latch that times out or ignores one source. Over-temperature is held long to confirm a single pulse per event, and pass-through is driven with the run gate low and an overcurrent pulse to show that neither disturbs it.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BOOT   = 3'd1,
        ST_STOP   = 3'd2,
        ST_RUN    = 3'd3,
        ST_HICCUP = 3'd4,
        ST_LATCH  = 3'd5,
        ST_THERM  = 3'd6,
        ST_BYPASS = 3'd7
    } seq_state_e;

    localparam logic [1:0] FM_BYPASS = 2'd3;
    localparam logic [1:0] OC_HICCUP = 2'd0;
    localparam logic [1:0] OC_LATCH  = 2'd1;

    typedef struct packed {
        logic sw_en;
        logic byp_on;
        logic dis_on;
    } drive_s;

    typedef struct packed {
        logic ss;
        logic hiccup;
        logic latch;
        logic therm;
    } event_s;

    function automatic drive_s decode_drive(seq_state_e st, logic dis_en);
        drive_s d;
        d.sw_en  = (st == ST_RUN);
        d.byp_on = (st == ST_BYPASS);
        d.dis_on = (st == ST_IDLE) || ((st == ST_STOP) && dis_en);
        return d;
    endfunction

endpackage

// File: rtl/conv_seq_edge.sv
module conv_seq_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = din[i] & ~prev_q[i];
    end
endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
    parameter int LIMIT      = 4,
    parameter bit START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int          W       = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM    = W'(LIMIT);
    localparam logic [W-1:0] RST_VAL = START_FULL ? LIM : '0;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                     cnt_q <= RST_VAL;
        else if (clr)                cnt_q <= '0;
        else if (inc && cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q >= LIM);
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_pin,
    input  logic       en_ovr,
    input  logic       uvlo_ok,
    input  logic       run_bit,
    input  logic       oc_flag,
    input  logic       ot_flag,
    input  logic [1:0] fmode,
    input  logic [1:0] oc_mode,
    input  logic       otp_done,
    input  logic       hic_done,
    input  logic       gap_ok,
    input  logic       pin_rise,
    input  logic       run_rise,
    output seq_state_e st_q,
    output logic       gap_clr,
    output event_s     ev_q
);
    seq_state_e nxt;
    event_s     ev;
    logic       pwr_ok;
    logic       want_byp;

    assign pwr_ok   = uvlo_ok && (en_pin || en_ovr);
    assign want_byp = (fmode == FM_BYPASS);

    always_comb begin
        nxt = st_q;
        ev  = '0;
        if (!pwr_ok) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: nxt = ST_BOOT;
                ST_BOOT: if (otp_done) nxt = ST_STOP;
                ST_STOP: begin
                    if (want_byp) begin
                        if (gap_ok) nxt = ST_BYPASS;
                    end else if (run_bit) begin
                        nxt   = ST_RUN;
                        ev.ss = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (want_byp && gap_ok) begin
                        nxt = ST_BYPASS;
                    end else if (!run_bit) begin
                        nxt = ST_STOP;
                    end else if (ot_flag) begin
                        nxt      = ST_THERM;
                        ev.therm = 1'b1;
                    end else if (oc_flag && oc_mode == OC_HICCUP) begin
                        nxt       = ST_HICCUP;
                        ev.hiccup = 1'b1;
                    end else if (oc_flag && oc_mode == OC_LATCH) begin
                        nxt      = ST_LATCH;
                        ev.latch = 1'b1;
                    end
                end
                ST_HICCUP: if (hic_done) nxt = ST_STOP;
                ST_LATCH:  if (run_rise || pin_rise) nxt = ST_STOP;
                ST_THERM:  if (!ot_flag) nxt = ST_STOP;
                ST_BYPASS: if (!want_byp && gap_ok) nxt = ST_STOP;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    assign gap_clr = (st_q == ST_BYPASS) != (nxt == ST_BYPASS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            ev_q <= '0;
        end else begin
            st_q <= nxt;
            ev_q <= ev;
        end
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int OTP_CYCLES = 125,
    parameter int HICCUP_MS  = 100,
    parameter int BYP_GAP_MS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_pin,
    input  logic       uvlo_ok,
    input  logic       oc_flag,
    input  logic       ot_flag,
    input  logic       run_bit,
    input  logic       en_ovr,
    input  logic       dis_en,
    input  logic [1:0] fmode,
    input  logic [1:0] oc_mode,
    input  logic       ms_tick,
    output logic       sw_en,
    output logic       byp_on,
    output logic       dis_on,
    output logic       ss_req,
    output logic       hiccup_evt,
    output logic       latch_evt,
    output logic       therm_evt
);
    seq_state_e st;
    event_s     ev;
    drive_s     drv;
    logic [1:0] rises;
    logic       otp_done, hic_done, gap_ok, gap_clr;

    conv_seq_edge #(.W(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  ({run_bit, en_pin}),
        .rise (rises)
    );

    conv_seq_timer #(.LIMIT(OTP_CYCLES), .START_FULL(1'b0)) u_otp (
        .clk  (clk),
        .rst  (rst),
        .clr  (st != ST_BOOT),
        .inc  (1'b1),
        .done (otp_done)
    );

    conv_seq_timer #(.LIMIT(HICCUP_MS), .START_FULL(1'b0)) u_hic (
        .clk  (clk),
        .rst  (rst),
        .clr  (st != ST_HICCUP),
        .inc  (ms_tick),
        .done (hic_done)
    );

    conv_seq_timer #(.LIMIT(BYP_GAP_MS), .START_FULL(1'b1)) u_gap (
        .clk  (clk),
        .rst  (rst),
        .clr  (gap_clr),
        .inc  (ms_tick),
        .done (gap_ok)
    );

    conv_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en_pin   (en_pin),
        .en_ovr   (en_ovr),
        .uvlo_ok  (uvlo_ok),
        .run_bit  (run_bit),
        .oc_flag  (oc_flag),
        .ot_flag  (ot_flag),
        .fmode    (fmode),
        .oc_mode  (oc_mode),
        .otp_done (otp_done),
        .hic_done (hic_done),
        .gap_ok   (gap_ok),
        .pin_rise (rises[0]),
        .run_rise (rises[1]),
        .st_q     (st),
        .gap_clr  (gap_clr),
        .ev_q     (ev)
    );

    assign drv        = decode_drive(st, dis_en);
    assign sw_en      = drv.sw_en;
    assign byp_on     = drv.byp_on;
    assign dis_on     = drv.dis_on;
    assign ss_req     = ev.ss;
    assign hiccup_evt = ev.hiccup;
    assign latch_evt  = ev.latch;
    assign therm_evt  = ev.therm;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
    parameter int BYP_GAP_MS = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       en_pin,
    input logic       en_ovr,
    input logic       uvlo_ok,
    input logic       run_bit,
    input logic       oc_flag,
    input logic       ot_flag,
    input logic [1:0] fmode,
    input logic [1:0] oc_mode,
    input logic       ms_tick,
    input logic       sw_en,
    input logic       byp_on,
    input logic       dis_on,
    input logic       ss_req,
    input logic       hiccup_evt,
    input logic       latch_evt,
    input logic       therm_evt
);
    localparam int CW = $clog2(BYP_GAP_MS + 1) + 1;
    localparam logic [CW-1:0] GAP = CW'(BYP_GAP_MS);

    logic          byp_prev, tick_d;
    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_prev <= 1'b0;
            tick_d   <= 1'b0;
            gap_cnt  <= GAP;
        end else begin
            byp_prev <= byp_on;
            tick_d   <= ms_tick;
            if (byp_on != byp_prev)         gap_cnt <= '0;
            else if (tick_d && gap_cnt < GAP) gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R12
    excl_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sw_en, byp_on, dis_on}));

    // R11
    power_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !uvlo_ok |=> (!sw_en && !byp_on));

    // R5
    hiccup_once_chk: assert property (@(posedge clk) disable iff (rst)
        hiccup_evt |=> !hiccup_evt);

    // R5
    hiccup_off_chk: assert property (@(posedge clk) disable iff (rst)
        hiccup_evt |-> !sw_en);

    // R6
    latch_off_chk: assert property (@(posedge clk) disable iff (rst)
        latch_evt |-> !sw_en);

    // R8
    therm_off_chk: assert property (@(posedge clk) disable iff (rst)
        therm_evt |-> (!sw_en && !byp_on));

    // R2
    ss_run_chk: assert property (@(posedge clk) disable iff (rst)
        ss_req |-> sw_en);

    // R7
    limit_only_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_en && oc_flag && oc_mode[1] && !ot_flag && run_bit && uvlo_ok
         && (en_pin || en_ovr) && fmode != 2'd3) |=> sw_en);

    // R9
    byp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byp_on && fmode == 2'd3 && uvlo_ok && (en_pin || en_ovr)) |=> byp_on);

    // R10
    byp_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((byp_on != byp_prev) && $past(uvlo_ok && (en_pin || en_ovr)))
        |-> (gap_cnt >= GAP));
endmodule

bind conv_seq conv_seq_chk #(.BYP_GAP_MS(BYP_GAP_MS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_pin     (en_pin),
    .en_ovr     (en_ovr),
    .uvlo_ok    (uvlo_ok),
    .run_bit    (run_bit),
    .oc_flag    (oc_flag),
    .ot_flag    (ot_flag),
    .fmode      (fmode),
    .oc_mode    (oc_mode),
    .ms_tick    (ms_tick),
    .sw_en      (sw_en),
    .byp_on     (byp_on),
    .dis_on     (dis_on),
    .ss_req     (ss_req),
    .hiccup_evt (hiccup_evt),
    .latch_evt  (latch_evt),
    .therm_evt  (therm_evt)
);

// File: tb/conv_seq_test.sv
module conv_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int OTP  = 5;
    localparam int HIC  = 4;
    localparam int GAP  = 2;
    localparam int TICK = 10;

    logic clk, rst;
    logic en_pin, uvlo_ok, oc_flag, ot_flag, run_bit, en_ovr, dis_en, ms_tick;
    logic [1:0] fmode, oc_mode;
    logic sw_en, byp_on, dis_on, ss_req, hiccup_evt, latch_evt, therm_evt;

    int n_chk = 0, n_err = 0;
    int n_hic = 0, n_lat = 0, n_ot = 0, n_excl = 0;

    conv_seq #(.OTP_CYCLES(OTP), .HICCUP_MS(HIC), .BYP_GAP_MS(GAP)) uut (
        .clk(clk), .rst(rst), .en_pin(en_pin), .uvlo_ok(uvlo_ok),
        .oc_flag(oc_flag), .ot_flag(ot_flag), .run_bit(run_bit),
        .en_ovr(en_ovr), .dis_en(dis_en), .fmode(fmode), .oc_mode(oc_mode),
        .ms_tick(ms_tick), .sw_en(sw_en), .byp_on(byp_on), .dis_on(dis_on),
        .ss_req(ss_req), .hiccup_evt(hiccup_evt), .latch_evt(latch_evt),
        .therm_evt(therm_evt)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        ms_tick = 1'b0;
        forever begin
            repeat (TICK - 1) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (hiccup_evt) n_hic++;
        if (latch_evt)  n_lat++;
        if (therm_evt)  n_ot++;
        if (int'(sw_en) + int'(byp_on) + int'(dis_on) > 1) n_excl++;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_sw(input int maxc, output int cyc);
        cyc = 0;
        while (!sw_en && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic oc_pulse();
        oc_flag = 1'b1;
        @(negedge clk);
        oc_flag = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; en_pin = 0; uvlo_ok = 0; oc_flag = 0; ot_flag = 0;
        run_bit = 0; en_ovr = 0; dis_en = 0; fmode = 0; oc_mode = 0;
        step(3);
        rst = 1'b0;
        step(2);
        chk("R1 sw_en", sw_en, 0);
        chk("R1 byp_on", byp_on, 0);
        chk("R1 dis_on", dis_on, 1);
        chk("R1 pulses", {ss_req, hiccup_evt, latch_evt, therm_evt}, 0);
    endtask

    task automatic t_startup();
        int c;
        uvlo_ok = 1; run_bit = 1; en_pin = 1;
        wait_sw(50, c);
        chk_rng("R2 boot delay", c, OTP, OTP + 4);
        chk("R2 ss at start", ss_req, 1);
        step(1);
        chk("R2 ss one cycle", ss_req, 0);
        chk("R2 running", sw_en, 1);
    endtask

    task automatic t_rungate();
        int c;
        dis_en = 0; run_bit = 0;
        step(2);
        chk("R3 run gate off", sw_en, 0);
        chk("R4 no discharge", dis_on, 0);
        dis_en = 1;
        step(1);
        chk("R4 discharge by field", dis_on, 1);
        run_bit = 1;
        step(2);
        chk("R3 run gate on", sw_en, 1);
        en_ovr = 1; en_pin = 0;
        step(5);
        chk("R3 override holds", sw_en, 1);
        en_ovr = 0;
        step(2);
        chk("R4 pin low off", sw_en, 0);
        chk("R4 pin low discharge", dis_on, 1);
        en_pin = 1;
        wait_sw(50, c);
        chk("R2 restart", sw_en, 1);
    endtask

    task automatic t_hiccup();
        int c, h0;
        h0 = n_hic;
        oc_mode = 2'd0;
        oc_pulse();
        chk("R5 stop", sw_en, 0);
        chk("R5 pulse", hiccup_evt, 1);
        step((HIC - 1) * TICK);
        chk("R5 still waiting", sw_en, 0);
        wait_sw(4 * TICK, c);
        chk("R5 restarted", sw_en, 1);
        chk("R5 soft start", ss_req, 1);
        chk("R5 pulse count", n_hic - h0, 1);
    endtask

    task automatic t_latch();
        int c, l0, h0;
        l0 = n_lat; h0 = n_hic;
        oc_mode = 2'd1;
        oc_pulse();
        chk("R6 stop", sw_en, 0);
        chk("R6 pulse", latch_evt, 1);
        step(80);
        chk("R6 held off", sw_en, 0);
        chk("R6 no hiccup", n_hic - h0, 0);
        run_bit = 0;
        step(1);
        run_bit = 1;
        step(3);
        chk("R6 run edge clears", sw_en, 1);
        oc_pulse();
        chk("R6 stop again", sw_en, 0);
        en_pin = 0;
        step(1);
        en_pin = 1;
        wait_sw(50, c);
        chk("R6 pin edge clears", sw_en, 1);
        chk("R6 pulse count", n_lat - l0, 2);
    endtask

    task automatic t_limit();
        int e0;
        e0 = n_hic + n_lat + n_ot;
        oc_mode = 2'd2; oc_flag = 1;
        step(20);
        chk("R7 mode 2 runs", sw_en, 1);
        oc_mode = 2'd3;
        step(20);
        chk("R7 mode 3 runs", sw_en, 1);
        oc_flag = 0;
        chk("R7 no events", n_hic + n_lat + n_ot - e0, 0);
    endtask

    task automatic t_thermal();
        int c, t0;
        t0 = n_ot;
        ot_flag = 1;
        step(1);
        chk("R8 stop", sw_en, 0);
        chk("R8 pulse", therm_evt, 1);
        step(30);
        chk("R8 held off", sw_en, 0);
        chk("R8 one pulse", n_ot - t0, 1);
        ot_flag = 0;
        wait_sw(10, c);
        chk("R8 recovered", sw_en, 1);
        chk("R8 soft start", ss_req, 1);
    endtask

    task automatic t_bypass();
        int c, h0;
        oc_mode = 2'd0;
        fmode = 2'd3;
        c = 0;
        while (!byp_on && c < 5) begin step(1); c++; end
        chk("R9 enter pass-through", byp_on, 1);
        chk("R9 no switching", sw_en, 0);
        fmode = 2'd0;
        c = 0;
        while (byp_on && c < 60) begin step(1); c++; end
        chk_rng("R10 exit spacing", c, (GAP - 1) * TICK, 60);
        chk("R10 exit done", byp_on, 0);
        fmode = 2'd3;
        c = 0;
        while (!byp_on && c < 60) begin step(1); c++; end
        chk_rng("R10 entry spacing", c, (GAP - 1) * TICK, 60);
        run_bit = 0;
        step(3);
        chk("R9 holds with run low", byp_on, 1);
        h0 = n_hic;
        oc_pulse();
        step(2);
        chk("R9 oc ignored", byp_on, 1);
        chk("R9 no hiccup", n_hic - h0, 0);
        fmode = 2'd1; run_bit = 1;
        wait_sw(60, c);
        chk("R9 ultrasonic runs", sw_en, 1);
        chk("R9 left pass-through", byp_on, 0);
    endtask

    task automatic t_loss();
        int c;
        oc_mode = 2'd0;
        oc_pulse();
        step(3);
        uvlo_ok = 0;
        step(2);
        chk("R11 off on loss", sw_en, 0);
        chk("R11 no pass-through", byp_on, 0);
        uvlo_ok = 1;
        wait_sw(50, c);
        chk_rng("R11 hiccup cancelled", c, OTP, OTP + 4);
        en_pin = 0;
        step(1);
        chk("R11 pin loss off", sw_en, 0);
        chk("R11 pin loss discharge", dis_on, 1);
        en_pin = 1;
        wait_sw(50, c);
        chk("R11 back up", sw_en, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_rungate();
        t_hiccup();
        t_latch();
        t_limit();
        t_thermal();
        t_bypass();
        t_loss();
        chk("R12 exclusive drives", n_excl, 0);
        summary();
        $finish;
    end
endmodule